// File: doc/BRIEF.md
# Collision Backoff Delay Timer

After a collision, a MAC must hold off for a random number of slot times before it sends the frame again. This block measures that wait. The caller gives it the attempt number and pulses `start`. The block then draws a pseudo-random slot count, clears its counters and counts bit-time ticks in groups of one slot. When the last slot expires it pulses `done`, and the caller may then transmit. Collision detection, jamming and the count of attempts are left to the caller.

The random draw comes from the low bits of a free-running linear feedback shift register. Only as many bits are kept as the current exponent allows. The exponent is the attempt number, capped at a maximum. Each node loads its own seed into the register during reset, so two nodes that collide with each other do not pick the same sequence of delays.

A mode input selects how carrier activity is handled. When the deferring mode is on, any tick that arrives while receive carrier is present is not counted. This lengthens the wait on a busy medium. When the mode is off, carrier has no effect.

The controller has two states. `BO_IDLE` waits for `start`. `BO_COUNT` counts ticks and slots. The transitions are named as follows:
- **launch**: `BO_IDLE` goes to `BO_COUNT` when `start` arrives with a non-zero draw.
- **instant**: on `start` with a zero draw, the block stays in or returns to `BO_IDLE` and pulses `done`.
- **restart**: `BO_COUNT` goes to `BO_COUNT` on a new `start` with a non-zero draw. The counters are reloaded.
- **expire**: `BO_COUNT` goes to `BO_IDLE` on the final counted tick, and `done` is pulsed.

Top module: `backoff_timer`

## Requirements
- R1: The exponent is k = min(`retry_num`, MAX_EXP), with MAX_EXP = 10. The drawn slot count r satisfies 0 <= r < 2^k, so `retry_num` = 0 always gives r = 0. Whenever `retry_num` is 10 or more, draws of 512 or above must be possible.
- R2: The wait between `start` and `done` is exactly r * SLOT_TICKS counted ticks, which is always a whole number of slots.
- R3: `done` is high for exactly one cycle. It is high in the cycle that follows the edge at which the final tick is counted. `busy` is high while slots remain to be counted and is low from the cycle in which `done` is high.
- R4: When r = 0, `done` is high in the cycle right after the `start` edge, and `busy` stays low.
- R5: When `defer_mode` = 1, a tick that arrives while `carrier` = 1 is not counted. Counting resumes when carrier drops.
- R6: When `defer_mode` = 0, `carrier` has no effect, and every `bit_tick` in `BO_COUNT` is counted.
- R7: A `start` that arrives during `BO_COUNT` abandons the current wait. It makes a fresh draw and restarts the tick count of the slot from zero.
- R8: The random register is loaded from `node_seed` while `rst_n` is low, and it advances on every clock edge. Nodes with different seeds, given the same stimulus, produce different sequences of delays.
- R9: During reset and after it, `done` = 0 and `busy` = 0 until a `start` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_seed | input | LFSR_W (16) | Per-node seed, loaded during reset |
| retry_num | input | RETRY_W (5) | Attempt number n, sampled with `start` |
| start | input | 1 | Begin a new wait; restarts the timer if it is already running |
| bit_tick | input | 1 | One pulse per bit time |
| carrier | input | 1 | Receive carrier sensed |
| defer_mode | input | 1 | 1 = do not count ticks while carrier is present |
| busy | output | 1 | Wait in progress (state `BO_COUNT`) |
| done | output | 1 | One-cycle pulse at the end of the wait |

## Verification
The hardest case to produce from the ports is a wait that ends at the correct tick while ticks and carrier are dense and randomly mixed in deferring mode. The drawn value is not visible, so the bench counts effective ticks itself. It then checks that the total is an exact multiple of the slot and lies below the range bound. A single miscounted or frozen tick breaks that divisibility. High draws and seed independence are reached statistically. Two instances with different seeds run side by side on the same stimulus over many trials at capped exponents. The bench then requires that some draw reached the upper half of the range and that the two instances' delays differed at least once.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
    typedef enum logic [0:0] {
        BO_IDLE  = 1'b0,
        BO_COUNT = 1'b1
    } bo_state_t;
endpackage

// File: rtl/bo_lfsr.sv
// Free-running Galois LFSR, seeded during reset; exposes its low bits.
module bo_lfsr #(
    parameter int              LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter int              OUT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed,
    output logic [OUT_W-1:0]  value
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] seed_nz;
    logic [LFSR_W-1:0] step;

    // an all-zero state would lock the register
    assign seed_nz = (seed == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed;
    assign step    = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= seed_nz;
        else        state_q <= step;
    end

    assign value = state_q[OUT_W-1:0];

    // R8: the register never reaches the locked all-zero state
    a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/bo_range_mask.sv
// Keeps the low min(n, MAX_EXP) bits of the random value.
module bo_range_mask #(
    parameter int RETRY_W = 5,
    parameter int MAX_EXP = 10
) (
    input  logic [RETRY_W-1:0] retry_num,
    input  logic [MAX_EXP-1:0] rand_in,
    output logic [MAX_EXP-1:0] draw
);
    localparam logic [RETRY_W-1:0] EXP_CAP = RETRY_W'(MAX_EXP);

    logic [RETRY_W-1:0] exp_k;
    logic [MAX_EXP-1:0] keep;

    assign exp_k = (retry_num > EXP_CAP) ? EXP_CAP : retry_num;

    for (genvar i = 0; i < MAX_EXP; i++) begin : g_keep
        localparam logic [RETRY_W-1:0] IDX = RETRY_W'(i);
        assign keep[i] = (exp_k > IDX);
    end

    assign draw = rand_in & keep;
endmodule

// File: rtl/bo_slot_counter.sv
// Counts ticks within a slot and the number of slots remaining.
module bo_slot_counter #(
    parameter int SLOT_TICKS = 512,
    parameter int SLOT_CNT_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SLOT_CNT_W-1:0] load_slots,
    input  logic                  advance,
    output logic                  last
);
    localparam int                TICK_W   = $clog2(SLOT_TICKS + 1);
    localparam logic [TICK_W-1:0] TICK_TOP = TICK_W'(SLOT_TICKS - 1);

    logic [TICK_W-1:0]     tick_cnt;
    logic [SLOT_CNT_W-1:0] slots_left;
    logic                  slot_end;

    assign slot_end = advance && (slots_left != '0) && (tick_cnt == TICK_TOP);
    assign last     = slot_end && (slots_left == SLOT_CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt   <= '0;
            slots_left <= '0;
        end else if (load) begin
            tick_cnt   <= '0;
            slots_left <= load_slots;
        end else if (advance && (slots_left != '0)) begin
            if (slot_end) begin
                tick_cnt   <= '0;
                slots_left <= slots_left - SLOT_CNT_W'(1);
            end else begin
                tick_cnt <= tick_cnt + TICK_W'(1);
            end
        end
    end

    // R5: without a counted tick or a load, nothing moves
    a_r5_hold_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(tick_cnt) && $stable(slots_left)));
    // R2: the in-slot counter never passes one slot
    a_r2_tick_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= TICK_TOP);
    // R7: a load always restarts the slot from tick zero
    a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tick_cnt == '0));
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
    import backoff_pkg::*;
#(
    parameter int              SLOT_TICKS = 512,
    parameter int              MAX_EXP    = 10,
    parameter int              RETRY_W    = 5,
    parameter int              LFSR_W     = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] node_seed,
    input  logic [RETRY_W-1:0] retry_num,
    input  logic              start,
    input  logic              bit_tick,
    input  logic              carrier,
    input  logic              defer_mode,
    output logic              busy,
    output logic              done
);
    bo_state_t          state_q, state_d;
    logic [MAX_EXP-1:0] rand_bits;
    logic [MAX_EXP-1:0] draw;
    logic               draw_zero;
    logic               advance;
    logic               last;

    bo_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .OUT_W(MAX_EXP)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .seed(node_seed), .value(rand_bits)
    );

    bo_range_mask #(.RETRY_W(RETRY_W), .MAX_EXP(MAX_EXP)) u_mask (
        .retry_num(retry_num), .rand_in(rand_bits), .draw(draw)
    );

    assign draw_zero = (draw == '0);
    // deferring mode drops ticks seen under carrier
    assign advance   = (state_q == BO_COUNT) && bit_tick && !(defer_mode && carrier);

    bo_slot_counter #(.SLOT_TICKS(SLOT_TICKS), .SLOT_CNT_W(MAX_EXP)) u_slots (
        .clk(clk), .rst_n(rst_n), .load(start), .load_slots(draw),
        .advance(advance && !start), .last(last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BO_IDLE: begin
                if (start && !draw_zero) state_d = BO_COUNT;      // launch
            end
            BO_COUNT: begin
                if (start)     state_d = draw_zero ? BO_IDLE : BO_COUNT; // instant / restart
                else if (last) state_d = BO_IDLE;                  // expire
            end
            default: state_d = BO_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BO_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start ? draw_zero : last;
    end

    assign busy = (state_q == BO_COUNT);

    // R4: a zero draw completes at once without entering the count state
    a_r4_zero_draw: assert property (@(posedge clk) disable iff (!rst_n)
        (start && draw_zero) |=> (done && !busy));
    // R7: a non-zero draw always (re)enters counting with no completion
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !draw_zero) |=> (busy && !done));
    // R3: completion only follows a start or a running count
    a_r3_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(busy)));
    // R3: leaving the count state without a new start always completes
    a_r3_exit_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(start)) |-> done);
endmodule

// File: tb/sim_backoff_timer.sv
module sim_backoff_timer;
    localparam int SLOT  = 8;
    localparam int MAXE  = 10;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  retry_num = '0;
    logic        start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        carrier = 1'b0;
    logic        defer_mode = 1'b0;
    logic        busy0, done0, busy1, done1;

    int checks = 0;
    int errors = 0;
    int seed_diffs = 0;
    bit seen_high = 1'b0;

    always #5 clk = ~clk;

    backoff_timer #(.SLOT_TICKS(SLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .node_seed(16'h1D2F), .retry_num(retry_num),
        .start(start), .bit_tick(bit_tick), .carrier(carrier),
        .defer_mode(defer_mode), .busy(busy0), .done(done0)
    );
    backoff_timer #(.SLOT_TICKS(SLOT)) u1 (
        .clk(clk), .rst_n(rst_n), .node_seed(16'h8A71), .retry_num(retry_num),
        .start(start), .bit_tick(bit_tick), .carrier(carrier),
        .defer_mode(defer_mode), .busy(busy1), .done(done1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int kexp(input int n);
        return (n > MAXE) ? MAXE : n;
    endfunction

    // checks a measured delay against R1/R2
    task automatic judge(input int ticks, input int n, input string who);
        int q;
        q = ticks / SLOT;
        check((ticks % SLOT) == 0, {"R2 whole slots ", who}, ticks % SLOT, 0);
        check(q < (1 << kexp(n)), {"R1 draw range ", who}, q, (1 << kexp(n)) - 1);
        if (kexp(n) == MAXE && q >= 512) seen_high = 1'b1;
    endtask

    task automatic trial(input int n, input bit mode, input int tick_pct,
                         input int car_pct, input bit pre_restart);
        int  cnt0, cnt1, cyc;
        bit  fin0, fin1, pend0, pend1, eff;
        if (pre_restart) begin
            // R7: launch a wait, then abandon it part-way through a slot
            @(negedge clk);
            retry_num = 5'(n); defer_mode = mode; start = 1'b1; bit_tick = 1'b0;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < SLOT / 2 + 1; i++) begin
                bit_tick = 1'b1; carrier = 1'b0;
                @(negedge clk);
            end
        end else begin
            @(negedge clk);
        end
        retry_num = 5'(n); defer_mode = mode; start = 1'b1; bit_tick = 1'b0;
        carrier = ($urandom_range(99) < car_pct);
        @(negedge clk);
        start = 1'b0;
        cnt0 = 0; cnt1 = 0; cyc = 0;
        fin0 = 0; fin1 = 0; pend0 = 0; pend1 = 0;
        while (!(fin0 && fin1 && !pend0 && !pend1) && cyc < LIMIT) begin
            if (pend0) begin
                check(!done0 && !busy0, "R3 single pulse u0", int'(done0), 0);
                pend0 = 0;
            end
            if (pend1) begin
                check(!done1, "R3 single pulse u1", int'(done1), 0);
                pend1 = 0;
            end
            if (!fin0 && done0) begin
                fin0 = 1; pend0 = 1;
                check(!busy0, "R3 busy low with done", int'(busy0), 0);
                judge(cnt0, n, "u0");
                if (n == 0) check(cnt0 == 0, "R4 zero draw immediate", cnt0, 0);
            end
            if (!fin1 && done1) begin
                fin1 = 1; pend1 = 1;
                judge(cnt1, n, "u1");
            end
            if (!fin0 && n == 0) check(1'b0, "R4 done missing after start", 0, 1);
            if (!fin0 && n == 0) fin0 = 1;
            bit_tick = ($urandom_range(99) < tick_pct);
            carrier  = ($urandom_range(99) < car_pct);
            eff = bit_tick && !(mode && carrier);
            @(posedge clk);
            if (!fin0 && eff) cnt0++;
            if (!fin1 && eff) cnt1++;
            @(negedge clk);
            cyc++;
        end
        if (cyc >= LIMIT) check(1'b0, "R2 watchdog expired", cyc, LIMIT);
        if (n >= 4 && cnt0 != cnt1) seed_diffs++;
        bit_tick = 1'b0; carrier = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R9: outputs quiet in and after reset
        #1;
        check(!done0 && !busy0, "R9 reset state", int'({busy0, done0}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done0 && !busy0, "R9 after reset", int'({busy0, done0}), 0);
        repeat (4) @(negedge clk);
        check(!done0 && !busy0, "R9 idle without start", int'({busy0, done0}), 0);

        // R4 / R1: n = 0 always yields an immediate finish
        trial(0, 1'b0, 100, 0, 1'b0);
        trial(0, 1'b1, 50, 50, 1'b0);
        // R2: small exponents, dense and sparse ticks
        for (int i = 1; i <= 6; i++) trial(i, 1'b0, 100, 0, 1'b0);
        for (int i = 1; i <= 6; i++) trial(i, 1'b0, 40, 0, 1'b0);
        // R6: carrier toggling with deferring off
        for (int i = 0; i < 6; i++) trial(5, 1'b0, 70, 60, 1'b0);
        // R5: carrier toggling with deferring on
        for (int i = 0; i < 8; i++) trial(5, 1'b1, 80, 50, 1'b0);
        trial(3, 1'b1, 100, 90, 1'b0);
        // R7: restart in mid-count
        for (int i = 0; i < 5; i++) trial(4, 1'b0, 100, 0, 1'b1);
        trial(6, 1'b1, 90, 30, 1'b1);
        // R1: exponent capped at 10 for large n
        for (int i = 0; i < 16; i++) trial(10 + (i % 8), 1'b0, 100, 0, 1'b0);
        check(seen_high, "R1 upper half of capped range reached", int'(seen_high), 1);
        // R8: different seeds give different delays
        check(seed_diffs > 0, "R8 seed independence", seed_diffs, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 global watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule